// File: doc/BRIEF.md
# Raster-Timed Interrupt and NMI Generator

This block derives the interrupt sources of a CPU from the vertical progress of a raster video generator. It counts line-start strobes from the last frame-start strobe. When the count reaches the mid-screen line (128) and again when it reaches the end-of-display line (256), it raises a maskable interrupt request. The request is held on an active-low output until software acknowledges it by reading a status port. The same status read returns a flag that shows whether the raster has reached the bottom of the frame. Software can therefore poll for a known frame phase before it enables interrupts.

A second source produces non-maskable interrupt pulses at a non-uniform line cadence. Once it is armed, the source waits for the next frame start. It then counts a repeating pattern of eight intervals: six of 32 lines followed by two of 37 lines. Each expiry produces a short low pulse, so the CPU sees exactly one falling edge per event. All control is by single-cycle I/O strobes to four dedicated port addresses.

Top module: `vig_irq_gen`

## Requirements
- R1: With the maskable interrupt enabled, the line-start strobe that takes the count since the last frame-start strobe to 128, and the one that takes it to 256, each drive `int_n` low from the next clock. No other line count raises it.
- R2: Once low, `int_n` stays low through further line strobes until a read of port 0x4E. The clock edge that samples that read returns `int_n` high.
- R3: While `io_rd` is high with address 0x4E, `io_rdata` bit 0 is 1 exactly when at least 256 line strobes have been counted since the last frame strobe, and bits 7..1 are 0. For any other read address, or with no read, `io_rdata` is 0.
- R4: A write to port 0x4F with nonzero data enables the maskable interrupt. A write with zero data disables it and drops a pending request at once. While it is disabled, lines 128 and 256 leave `int_n` high.
- R5: A write to port 0x4C arms the NMI source without producing any pulse. Counting starts at the next frame strobe, and the first pulse follows the 32nd line strobe after that frame strobe.
- R6: Measured in line strobes from the starting frame strobe, the NMI intervals are 32, 32, 32, 32, 32, 32, 37, 37, and the pattern then repeats. Frame strobes do not disturb a running pattern.
- R7: Each NMI event holds `nmi_n` low for exactly 4 clocks, starting on the clock after the line strobe that ends the interval.
- R8: A write to port 0x4D stops the NMI source and ends any pulse in progress, so `nmi_n` is high from the next clock and no further pulses occur. A later write to 0x4C restarts the pattern at its first interval after the next frame strobe.
- R9: After reset, `int_n` and `nmi_n` are high, both sources are disabled and the line count is 0.
- R10: A frame strobe takes priority over a line strobe in the same cycle. The count becomes 0, so line 128 is reached 128 strobes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse at each video line start |
| frame_stb | input | 1 | One-cycle pulse at each frame start |
| io_rd | input | 1 | One-cycle I/O read strobe |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (status port only) |
| int_n | output | 1 | Active-low maskable interrupt request |
| nmi_n | output | 1 | Active-low non-maskable interrupt pulse |

## Verification
The maskable path is tested with line counts that stop one short of 128 and of 256 and then step across them. This separates an off-by-one comparison from a correct one. A read between events shows that the request is held and then cleared. The bottom flag is sampled at 255 and at 256. Runs with the source disabled, and a disable while a request is pending, separate a gating fault from a clearing fault. A frame strobe coinciding with a line strobe shows which one has priority. The NMI path runs a full pattern plus one interval, with a stray line burst before the starting frame. This tells a wrong interval order, a wrong long-interval length or an unsynchronised start apart from correct behaviour. A mid-pulse disable and a re-arm show that the pulse is truncated and that the pattern restarts at its first interval.

// File: rtl/vig_pkg.sv
// Package: shared types for the raster-timed interrupt generator.
// Assumes: nothing beyond IEEE 1800-2017.
package vig_pkg;

    // NMI sequencer state
    typedef enum logic [1:0] {
        NMI_OFF   = 2'd0,
        NMI_ARMED = 2'd1,
        NMI_RUN   = 2'd2
    } nmi_state_t;

    // Decoded single-cycle I/O commands
    typedef struct packed {
        logic int_ack;   // status read, acknowledges the maskable request
        logic int_wr;    // maskable enable register write
        logic int_val;   // value written to the maskable enable
        logic nmi_on;    // NMI arm
        logic nmi_off;   // NMI stop
    } io_cmd_t;

endpackage

// File: rtl/vig_io_decode.sv
// Module: vig_io_decode
// Turns I/O strobes and addresses into single-cycle commands and
// drives the status read data. The read data is combinational.
// Assumes: io_rd and io_wr are one-cycle strobes, never both high.
module vig_io_decode
    import vig_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int ST_PORT     = 8'h4E,
    parameter int INT_PORT    = 8'h4F,
    parameter int NMI_ON_PORT = 8'h4C,
    parameter int NMI_OFF_PORT= 8'h4D
) (
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              bottom,
    output io_cmd_t           cmd,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(ST_PORT);
    localparam logic [ADDR_W-1:0] A_INT = ADDR_W'(INT_PORT);
    localparam logic [ADDR_W-1:0] A_ON  = ADDR_W'(NMI_ON_PORT);
    localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(NMI_OFF_PORT);

    // Address match per command
    always_comb begin
        cmd.int_ack = io_rd && (io_addr == A_ST);
        cmd.int_wr  = io_wr && (io_addr == A_INT);
        cmd.int_val = |io_wdata;
        cmd.nmi_on  = io_wr && (io_addr == A_ON);
        cmd.nmi_off = io_wr && (io_addr == A_OFF);
    end

    // Status byte: bottom-of-frame flag in bit 0, zero otherwise
    always_comb begin
        rdata = '0;
        if (cmd.int_ack) begin
            rdata[0] = bottom;
        end
    end

endmodule

// File: rtl/vig_line_tracker.sv
// Module: vig_line_tracker
// Counts line strobes since the last frame strobe. It flags the
// mid-screen and end-of-display lines and reports the bottom-of-frame state.
// Assumes: strobes last one clock; the count saturates if frames stop.
module vig_line_tracker #(
    parameter int LINE_W   = 9,
    parameter int MID_LINE = 128,
    parameter int END_LINE = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic frame_stb,
    output logic mid_ev,
    output logic end_ev,
    output logic bottom
);

    localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] MID_M1  = LINE_W'(MID_LINE - 1);
    localparam logic [LINE_W-1:0] END_M1  = LINE_W'(END_LINE - 1);
    localparam logic [LINE_W-1:0] END_V   = LINE_W'(END_LINE);

    logic [LINE_W-1:0] line_cnt;
    logic              count_step;

    assign count_step = line_stb && !frame_stb;

    // Line counter: frame strobe wins, saturates at full scale
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (frame_stb) begin
            line_cnt <= '0;
        end else if (line_stb && (line_cnt != CNT_MAX)) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    // Events fire on the strobe that reaches each target line
    assign mid_ev = count_step && (line_cnt == MID_M1);
    assign end_ev = count_step && (line_cnt == END_M1);
    assign bottom = (line_cnt >= END_V);

    p_frame_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (line_cnt == '0));

    p_line_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_step && (line_cnt != CNT_MAX)) |=> (line_cnt == $past(line_cnt) + 1'b1));

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_stb && !frame_stb) |=> $stable(line_cnt));

endmodule

// File: rtl/vig_int_ctrl.sv
// Module: vig_int_ctrl
// Holds the maskable interrupt enable and the pending request. A new
// event takes priority over an acknowledge in the same cycle.
// Assumes: the event and command inputs are single-cycle pulses.
module vig_int_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic ack,
    input  logic en_wr,
    input  logic en_val,
    output logic pending
);

    logic int_en;
    logic dis_now;

    assign dis_now = en_wr && !en_val;

    // Enable register, written by the enable port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en <= 1'b0;
        end else if (en_wr) begin
            int_en <= en_val;
        end
    end

    // Pending request: disable clears, event sets, acknowledge clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (dis_now) begin
            pending <= 1'b0;
        end else if (set_ev && int_en) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    p_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && int_en && !dis_now) |=> pending);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack && !en_wr) |=> pending);

    p_ack_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_ev) |=> !pending);

    p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !pending);

endmodule

// File: rtl/vig_nmi_seq.sv
// Module: vig_nmi_seq
// Non-uniform NMI interval sequencer. It is armed by command, starts
// at the next frame strobe and walks a repeating table of interval lengths.
// Each expiry emits a fixed-length pulse.
// Assumes: line strobes are spaced further apart than the pulse length.
module vig_nmi_seq
    import vig_pkg::*;
#(
    parameter int SHORT_LINES = 32,
    parameter int LONG_LINES  = 37,
    parameter int SEQ_LEN     = 8,
    parameter int LONG_START  = 6,
    parameter int PULSE_CLKS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic frame_stb,
    input  logic arm,
    input  logic stop,
    output logic active
);

    localparam int CNT_W = $clog2(LONG_LINES + 1);
    localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam int PW    = $clog2(PULSE_CLKS + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LINES - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LINES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(SEQ_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_LONG   = IDX_W'(LONG_START);
    localparam logic [PW-1:0]    PULSE_V    = PW'(PULSE_CLKS);

    nmi_state_t        state;
    logic [CNT_W-1:0]  ivl_cnt;
    logic [IDX_W-1:0]  idx;
    logic [PW-1:0]     pulse_cnt;
    logic [CNT_W-1:0]  ivl_last;
    logic              fire;
    logic [IDX_W-1:0]  idx_next;

    // Length of the current interval, taken from its table position
    assign ivl_last = (idx >= IDX_LONG) ? LONG_LAST : SHORT_LAST;
    assign fire     = (state == NMI_RUN) && line_stb && !stop && (ivl_cnt == ivl_last);
    assign idx_next = (idx == IDX_LAST) ? '0 : idx + 1'b1;

    // Sequencer state, interval counter and table position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= NMI_OFF;
            ivl_cnt <= '0;
            idx     <= '0;
        end else if (stop) begin
            state   <= NMI_OFF;
            ivl_cnt <= '0;
            idx     <= '0;
        end else begin
            case (state)
                NMI_OFF: begin
                    if (arm) begin
                        state <= NMI_ARMED;
                    end
                end
                NMI_ARMED: begin
                    if (frame_stb) begin
                        state   <= NMI_RUN;
                        ivl_cnt <= '0;
                        idx     <= '0;
                    end
                end
                NMI_RUN: begin
                    if (fire) begin
                        ivl_cnt <= '0;
                        idx     <= idx_next;
                    end else if (line_stb) begin
                        ivl_cnt <= ivl_cnt + 1'b1;
                    end
                end
                default: state <= NMI_OFF;
            endcase
        end
    end

    // Pulse stretcher: loads on each event, cut short by stop
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            pulse_cnt <= '0;
        end else if (fire) begin
            pulse_cnt <= PULSE_V;
        end else if (pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign active = (pulse_cnt != '0);

    p_seq_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((ivl_cnt == '0) &&
                  (idx == (($past(idx) == IDX_LAST) ? '0 : $past(idx) + 1'b1))));

    p_pulse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !stop && (pulse_cnt > 1) && !fire) |=> active);

    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!active && (state == NMI_OFF)));

    p_armed_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NMI_ARMED) |-> !active);

endmodule

// File: rtl/vig_irq_gen.sv
// Module: vig_irq_gen (top)
// Raster-timed interrupt generator. A maskable request is raised at the
// mid-screen and end-of-display lines and is acknowledged by a status
// read. A separate NMI pulse train runs on a non-uniform line cadence.
// Assumes: synchronous active-low reset; one-cycle strobes on all inputs.
module vig_irq_gen
    import vig_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int LINE_W       = 9,
    parameter int MID_LINE     = 128,
    parameter int END_LINE     = 256,
    parameter int SHORT_LINES  = 32,
    parameter int LONG_LINES   = 37,
    parameter int SEQ_LEN      = 8,
    parameter int LONG_START   = 6,
    parameter int PULSE_CLKS   = 4,
    parameter int ST_PORT      = 8'h4E,
    parameter int INT_PORT     = 8'h4F,
    parameter int NMI_ON_PORT  = 8'h4C,
    parameter int NMI_OFF_PORT = 8'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              frame_stb,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              int_n,
    output logic              nmi_n
);

    io_cmd_t cmd;
    logic    mid_ev;
    logic    end_ev;
    logic    bottom;
    logic    int_pend;
    logic    nmi_act;

    vig_io_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ST_PORT     (ST_PORT),
        .INT_PORT    (INT_PORT),
        .NMI_ON_PORT (NMI_ON_PORT),
        .NMI_OFF_PORT(NMI_OFF_PORT)
    ) u_dec (
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .bottom  (bottom),
        .cmd     (cmd),
        .rdata   (io_rdata)
    );

    vig_line_tracker #(
        .LINE_W  (LINE_W),
        .MID_LINE(MID_LINE),
        .END_LINE(END_LINE)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .frame_stb(frame_stb),
        .mid_ev   (mid_ev),
        .end_ev   (end_ev),
        .bottom   (bottom)
    );

    vig_int_ctrl u_int (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (mid_ev || end_ev),
        .ack    (cmd.int_ack),
        .en_wr  (cmd.int_wr),
        .en_val (cmd.int_val),
        .pending(int_pend)
    );

    vig_nmi_seq #(
        .SHORT_LINES(SHORT_LINES),
        .LONG_LINES (LONG_LINES),
        .SEQ_LEN    (SEQ_LEN),
        .LONG_START (LONG_START),
        .PULSE_CLKS (PULSE_CLKS)
    ) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .frame_stb(frame_stb),
        .arm      (cmd.nmi_on),
        .stop     (cmd.nmi_off),
        .active   (nmi_act)
    );

    // Active-low outputs straight from registered state
    assign int_n = !int_pend;
    assign nmi_n = !nmi_act;

    p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0));

    p_ack_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.int_ack && !mid_ev && !end_ev) |=> int_n);

endmodule

// File: tb/vig_irq_gen_tb.sv
// Directed bench for vig_irq_gen: one task per scenario.
module vig_irq_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       frame_stb = 1'b0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       int_n;
    logic       nmi_n;

    int checks = 0;
    int errors = 0;
    int bl = 0;            // bench line count since last frame strobe
    int ev_cnt = 0;        // NMI falling edges seen
    int low_cnt = 0;       // clocks with nmi_n low
    int ev_line [0:15];
    logic prev_nmi = 1'b1;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    vig_irq_gen u_dut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .int_n(int_n), .nmi_n(nmi_n)
    );

    // NMI monitor sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_nmi && !nmi_n) begin
                if (ev_cnt < 16) ev_line[ev_cnt] = bl;
                ev_cnt = ev_cnt + 1;
            end
            if (!nmi_n) low_cnt = low_cnt + 1;
            prev_nmi = nmi_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic line_pulse(input int gap);
        line_stb = 1'b1;
        bl = bl + 1;
        @(negedge clk);
        line_stb = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) line_pulse(6);
    endtask

    task automatic frame_pulse();
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        bl = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_wdata = 8'h00;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R9 int_n after reset", int_n, 1);
        chk("R9 nmi_n after reset", nmi_n, 1);
        chk("R3 idle rdata", io_rdata, 0);
        io_read(8'h4E, d);
        chk("R9 line count zero (status bit)", d, 0);
        chk("R9 int disabled after reset", int_n, 1);
    endtask

    task automatic t_int_events();
        logic [7:0] d;
        io_write(8'h4F, 8'hFF);
        frame_pulse();
        run_lines(127);
        chk("R1 no int at line 127", int_n, 1);
        run_lines(1);
        chk("R1 int at line 128", int_n, 0);
        run_lines(5);
        chk("R2 int held over lines", int_n, 0);
        io_read(8'h4E, d);
        chk("R3 status mid-frame", d, 0);
        chk("R2 ack releases int", int_n, 1);
        run_lines(122);
        io_read(8'h4E, d);
        chk("R3 status at line 255", d, 0);
        chk("R1 no int at line 255", int_n, 1);
        run_lines(1);
        chk("R1 int at line 256", int_n, 0);
        io_read(8'h55, d);
        chk("R3 other port reads zero", d, 0);
        chk("R2 other read keeps int", int_n, 0);
        io_read(8'h4E, d);
        chk("R3 status bottom flag", d, 1);
        chk("R2 ack at bottom", int_n, 1);
    endtask

    task automatic t_int_disable();
        io_write(8'h4F, 8'hFF);
        frame_pulse();
        run_lines(128);
        chk("R1 int raised before disable", int_n, 0);
        io_write(8'h4F, 8'h00);
        chk("R4 disable drops pending", int_n, 1);
        frame_pulse();
        run_lines(128);
        chk("R4 no int at 128 when disabled", int_n, 1);
        run_lines(128);
        chk("R4 no int at 256 when disabled", int_n, 1);
    endtask

    task automatic t_frame_priority();
        logic [7:0] d;
        io_write(8'h4F, 8'h01);
        frame_pulse();
        run_lines(100);
        frame_stb = 1'b1;
        line_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        line_stb = 1'b0;
        bl = 0;
        repeat (3) @(negedge clk);
        run_lines(127);
        chk("R10 frame wins, no int at 127", int_n, 1);
        run_lines(1);
        chk("R10 int at 128 after combined strobe", int_n, 0);
        io_read(8'h4E, d);
        io_write(8'h4F, 8'h00);
    endtask

    task automatic t_nmi_sequence();
        int exp_l [0:8] = '{32, 64, 96, 128, 160, 192, 229, 266, 298};
        io_write(8'h4C, 8'h00);
        run_lines(40);
        chk("R5 armed, no NMI before frame", ev_cnt, 0);
        chk("R5 nmi_n high while armed", nmi_n, 1);
        frame_pulse();
        run_lines(31);
        chk("R5 no NMI at line 31", ev_cnt, 0);
        run_lines(1);
        chk("R5 first NMI at line 32", ev_cnt, 1);
        frame_pulse();
        bl = 32;
        run_lines(266);
        chk("R6 event count over pattern", ev_cnt, 9);
        for (int i = 0; i < 9; i++) chk($sformatf("R6 event %0d line", i), ev_line[i], exp_l[i]);
        chk("R7 low clocks per event", low_cnt, 4 * ev_cnt);
    endtask

    task automatic t_nmi_stop();
        int n0;
        int guard;
        n0 = ev_cnt;
        guard = 0;
        while (nmi_n && guard < 40) begin
            line_pulse(1);
            guard++;
        end
        chk("R6 next event after wrap", bl, 330);
        chk("R7 pulse in progress", nmi_n, 0);
        io_write(8'h4D, 8'h00);
        chk("R8 stop ends pulse", nmi_n, 1);
        run_lines(80);
        chk("R8 no events after stop", ev_cnt, n0 + 1);
        io_write(8'h4C, 8'h00);
        frame_pulse();
        run_lines(31);
        chk("R8 restart no event at 31", ev_cnt, n0 + 1);
        run_lines(1);
        chk("R8 restart event at line 32", ev_cnt, n0 + 2);
        io_write(8'h4D, 8'h00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_int_events();
        t_int_disable();
        t_frame_priority();
        t_nmi_sequence();
        t_nmi_stop();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule